// File: doc/BRIEF.md
# Ramped Stereo Volume Attenuator with Mute Hold

This block scales a stereo stream of signed 24-bit samples by a linear volume code. One left/right pair enters on each output sample tick. The applied level is held in its own counter. That counter slews one code step per tick toward the requested target, so a change of target never causes a jump in gain. A target may change at any moment, including in the middle of a ramp. A shift flag raises the gain by a factor of four, which is about +12 dB, and products that overflow are clipped to the 24-bit range.

Two mechanisms silence the output. A direct mute request, sampled with each tick, forces that word to zero. Reset and a configuration-change pulse each start an automatic mute hold. The hold zeroes a fixed number of words and then releases by itself. The level ramp keeps running while the output is muted.

Top module: `vol_ramp_atten`

## Requirements
- R1: The target code is 11 bits wide. Any target above 0x400 is treated as 0x400, so the applied level never exceeds 1024.
- R2: With the shift flag low, each output word equals floor(sample × level / 1024). The level used is the value after that tick's step. Level 0 gives silence and level 1024 passes the sample unchanged.
- R3: With the shift flag high, each output word equals floor(sample × level / 256).
- R4: On each tick the level moves exactly one step toward the clamped target, or stays put if it already equals the target. Without a tick the level does not change.
- R5: When the target changes during a ramp, the level continues from its present value toward the new target.
- R6: After reset the level is 0x400, both outputs are zero and the valid strobe is low.
- R7: A word whose tick sees the mute request high is output as zero. The first tick that sees the request low outputs normal data.
- R8: After reset, the first 3072 words are zero and the 3073rd carries data. A configuration pulse in a cycle without a tick zeroes the next 3072 words. A pulse that coincides with a tick makes that tick's word the first of the 3072 zero words.
- R9: A scaled result above 8388607 is output as 8388607, and one below −8388608 is output as −8388608.
- R10: Each word appears on the outputs in the cycle after its tick, with the valid strobe high for exactly that cycle. Between words the outputs hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_tick | input | 1 | One-cycle strobe per output sample pair |
| smp_l_in | input | 24 | Left input sample, two's complement |
| smp_r_in | input | 24 | Right input sample, two's complement |
| target_code | input | 11 | Requested linear level, 0x400 = unity |
| gain_shift | input | 1 | High selects ×4 gain (+12 dB) |
| mute_req | input | 1 | Direct mute, sampled at each tick |
| cfg_change | input | 1 | One-cycle pulse that restarts the mute hold |
| smp_l_out | output | 24 | Scaled left word |
| smp_r_out | output | 24 | Scaled right word |
| out_valid | output | 1 | High for one cycle when a new word is on the outputs |

## Verification
The case most likely to go wrong is a configuration pulse landing on the same cycle as a sample tick. That tick must both emit a zero word and reload the hold, so that only 3071 further words are muted. The bench drives this pulse once between ticks and once on a tick, counts the zero words in each case, and compares them word by word against a behavioural model. A second overlap comes from the ramp running during a mute. The bench retargets the level while the mute and the hold are active, then checks that the first released word carries the level the ramp reached, not a stale one.

// File: rtl/vra_pkg.sv
// Package: shared types of the ramped volume attenuator.
// Assumes: included first in compile order.
package vra_pkg;
    // Direction the level counter takes on a tick.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/vra_level_ramp.sv
// Module: level slew counter. Clamps the requested code to unity and moves
// the applied level one step toward it on every sample tick.
// Assumes: smp_tick is a single-cycle strobe; CODE_W >= 2.
module vra_level_ramp
    import vra_pkg::*;
#(
    parameter int CODE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick,
    input  logic [CODE_W-1:0] target_code,
    output logic [CODE_W-1:0] lvl_next
);
    localparam int unsigned         UNITY_I = 1 << (CODE_W - 1);
    localparam logic [CODE_W-1:0]   UNITY   = UNITY_I[CODE_W-1:0];

    logic [CODE_W-1:0] lvl_q;
    logic [CODE_W-1:0] tgt_clamped;
    step_e             dir;

    // Clamp out-of-range targets and pick the step direction.
    always_comb begin
        tgt_clamped = (target_code > UNITY) ? UNITY : target_code;
        if (lvl_q < tgt_clamped)      dir = STEP_UP;
        else if (lvl_q > tgt_clamped) dir = STEP_DOWN;
        else                          dir = STEP_HOLD;
    end

    // Level value that takes effect at this tick.
    always_comb begin
        lvl_next = lvl_q;
        if (smp_tick) begin
            case (dir)
                STEP_UP:   lvl_next = lvl_q + 1'b1;
                STEP_DOWN: lvl_next = lvl_q - 1'b1;
                default:   lvl_next = lvl_q;
            endcase
        end
    end

    // Level register, unity after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= UNITY;
        else        lvl_q <= lvl_next;
    end

    // R1
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= UNITY);
    // R4
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |=> (lvl_q == $past(lvl_q) + 1'b1) || (lvl_q == $past(lvl_q) - 1'b1)
                     || (lvl_q == $past(lvl_q)));
    // R4
    level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(lvl_q));
endmodule

// File: rtl/vra_mute_hold.sv
// Module: mute decision. Combines the direct mute request with a hold
// counter that zeroes a fixed number of words after reset or a
// configuration pulse.
// Assumes: HOLD_WORDS >= 2; word_zero is only consumed on tick cycles.
module vra_mute_hold #(
    parameter int HOLD_WORDS = 3072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_tick,
    input  logic mute_req,
    input  logic cfg_change,
    output logic word_zero
);
    localparam int          HW        = $clog2(HOLD_WORDS + 1);
    localparam logic [HW-1:0] HOLD_FULL = HW'(HOLD_WORDS);
    localparam logic [HW-1:0] HOLD_LESS = HW'(HOLD_WORDS - 1);

    logic [HW-1:0] hold_cnt;

    // A word is zero when muted directly, when a pulse arrives, or during the hold.
    always_comb word_zero = mute_req || cfg_change || (hold_cnt != '0);

    // Hold counter: reload on reset or pulse, count down one per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                            hold_cnt <= HOLD_FULL;
        else if (cfg_change)                   hold_cnt <= smp_tick ? HOLD_LESS : HOLD_FULL;
        else if (smp_tick && hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
    end

    // R8
    hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HOLD_FULL);
    // R8
    hold_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> hold_cnt != '0);
endmodule

// File: rtl/vra_scale_sat.sv
// Module: one channel's multiply, gain-shift and clip to the sample width.
// Purely combinational.
// Assumes: level is unsigned and no larger than 2**(CODE_W-1).
module vra_scale_sat #(
    parameter int DATA_W = 24,
    parameter int CODE_W = 11
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic        [CODE_W-1:0] level,
    input  logic                     gain_shift,
    output logic signed [DATA_W-1:0] scaled
);
    localparam int PW = DATA_W + CODE_W + 1;
    localparam logic signed [PW-1:0] POS_MAX = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PW-1:0] NEG_MIN = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shd;

    // Product, divide by 1024 (or 256 when shifted), then clip.
    always_comb begin
        prod = sample * $signed({1'b0, level});
        shd  = gain_shift ? (prod >>> (CODE_W - 3)) : (prod >>> (CODE_W - 1));
        if (shd > POS_MAX)      scaled = POS_MAX[DATA_W-1:0];
        else if (shd < NEG_MIN) scaled = NEG_MIN[DATA_W-1:0];
        else                    scaled = shd[DATA_W-1:0];
    end
endmodule

// File: rtl/vol_ramp_atten.sv
// Module: top of the ramped stereo volume attenuator. Applies the slewed
// level to both channels and registers the result on each sample tick.
// Assumes: one tick per sample pair, ticks at least one cycle apart not required.
module vol_ramp_atten #(
    parameter int DATA_W     = 24,
    parameter int CODE_W     = 11,
    parameter int HOLD_WORDS = 3072
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_tick,
    input  logic signed [DATA_W-1:0] smp_l_in,
    input  logic signed [DATA_W-1:0] smp_r_in,
    input  logic        [CODE_W-1:0] target_code,
    input  logic                     gain_shift,
    input  logic                     mute_req,
    input  logic                     cfg_change,
    output logic signed [DATA_W-1:0] smp_l_out,
    output logic signed [DATA_W-1:0] smp_r_out,
    output logic                     out_valid
);
    localparam int NCH = 2;

    logic [CODE_W-1:0]        lvl_next;
    logic                     word_zero;
    logic signed [DATA_W-1:0] ch_in  [NCH];
    logic signed [DATA_W-1:0] ch_scl [NCH];
    logic signed [DATA_W-1:0] ch_q   [NCH];

    vra_level_ramp #(.CODE_W(CODE_W)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_tick   (smp_tick),
        .target_code(target_code),
        .lvl_next   (lvl_next)
    );

    vra_mute_hold #(.HOLD_WORDS(HOLD_WORDS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_tick  (smp_tick),
        .mute_req  (mute_req),
        .cfg_change(cfg_change),
        .word_zero (word_zero)
    );

    // Gather the channel inputs into an array.
    always_comb begin
        ch_in[0] = smp_l_in;
        ch_in[1] = smp_r_in;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        vra_scale_sat #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_scale (
            .sample    (ch_in[ch]),
            .level     (lvl_next),
            .gain_shift(gain_shift),
            .scaled    (ch_scl[ch])
        );

        // Output word register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)        ch_q[ch] <= '0;
            else if (smp_tick) ch_q[ch] <= word_zero ? '0 : ch_scl[ch];
        end
    end

    // Valid strobe follows the tick by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= smp_tick;
    end

    assign smp_l_out = ch_q[0];
    assign smp_r_out = ch_q[1];

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(smp_tick));
    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(smp_l_out) && $stable(smp_r_out));
    // R7
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick && mute_req |=> smp_l_out == '0 && smp_r_out == '0);
    // R8
    cfg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick && cfg_change |=> smp_l_out == '0 && smp_r_out == '0);
endmodule

// File: tb/vol_ramp_atten_bench.sv
`timescale 1ns/1ps
module vol_ramp_atten_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               tick = 1'b0;
    logic signed [23:0] in_l = '0, in_r = '0;
    logic [10:0]        tgt = 11'h400;
    logic               sh = 1'b0, mute = 1'b0, cfg = 1'b0;
    logic signed [23:0] out_l, out_r;
    logic               out_v;

    vol_ramp_atten u_vol_ramp_atten (
        .clk(clk), .rst_n(rst_n), .smp_tick(tick), .smp_l_in(in_l), .smp_r_in(in_r),
        .target_code(tgt), .gain_shift(sh), .mute_req(mute), .cfg_change(cfg),
        .smp_l_out(out_l), .smp_r_out(out_r), .out_valid(out_v)
    );

    int     checks = 0, errors = 0;
    bit     done = 1'b0;
    string  cur_req = "R6";
    int     m_lvl = 1024, m_hold = 3072;
    longint e_l = 0, e_r = 0;
    bit     e_v = 1'b0;

    function automatic longint scale(longint s, int lvl, bit shf);
        longint p = s * lvl;
        longint q = shf ? (p >>> 8) : (p >>> 10);
        if (q > 8388607)  q = 8388607;
        if (q < -8388608) q = -8388608;
        return q;
    endfunction

    // Advance the model with the driven inputs, then compare after the edge.
    task automatic cycle();
        bit zero;
        int t;
        if (!rst_n) begin
            m_lvl = 1024; m_hold = 3072; e_l = 0; e_r = 0; e_v = 0;
        end else begin
            e_v = tick;
            if (tick) begin
                t = (tgt > 1024) ? 1024 : int'(tgt);
                if (m_lvl < t) m_lvl++;
                else if (m_lvl > t) m_lvl--;
                zero = mute || cfg || (m_hold > 0);
                if (cfg) m_hold = 3071;
                else if (m_hold > 0) m_hold--;
                e_l = zero ? 0 : scale(longint'(in_l), m_lvl, sh);
                e_r = zero ? 0 : scale(longint'(in_r), m_lvl, sh);
            end else if (cfg) begin
                m_hold = 3072;
            end
        end
        @(negedge clk);
        checks++;
        if (longint'(out_l) != e_l || longint'(out_r) != e_r || out_v != e_v) begin
            errors++;
            $display("FAIL %s: got l=%0d r=%0d v=%0d, expected l=%0d r=%0d v=%0d",
                     cur_req, out_l, out_r, out_v, e_l, e_r, e_v);
        end
    endtask

    // One word: a tick cycle with the given samples, then an idle cycle.
    task automatic word(input logic signed [23:0] l, input logic signed [23:0] r);
        tick = 1'b1; in_l = l; in_r = r;
        cycle();
        tick = 1'b0;
        cycle();
    endtask

    task automatic rand_words(input int n);
        for (int i = 0; i < n; i++) word(24'($urandom), 24'($urandom));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R6";
        for (int i = 0; i < 4; i++) cycle();
        rst_n = 1'b1;
        cur_req = "R8";               // reset hold: 3072 zero words, ramp also running R5
        tgt = 11'h200;
        rand_words(500);
        tgt = 11'h400;
        rand_words(2572);
        cur_req = "R2";               // 3073rd word carries data at unity
        word(24'sh123456, -24'sd5);
        rand_words(20);
        cur_req = "R4";               // full sweep down to silence
        tgt = 11'h000;
        rand_words(1030);
        cur_req = "R5";
        tgt = 11'd600; rand_words(300);
        tgt = 11'd100; rand_words(600);
        cur_req = "R1";               // above-range target clamps to unity
        tgt = 11'h7FF; rand_words(1100);
        cur_req = "R9";               // shifted unity saturates both rails
        sh = 1'b1;
        word(24'sh7FFFFF, -24'sh800000);
        word(24'sh300000, -24'sh300000);
        rand_words(20);
        cur_req = "R3";
        tgt = 11'd200; rand_words(900);
        word(24'sh7FFFFF, -24'sh800000);
        cur_req = "R7";
        sh = 1'b0; tgt = 11'h400;
        mute = 1'b1; rand_words(10);
        mute = 1'b0; rand_words(10);
        mute = 1'b1; word(24'sh400000, 24'sh400000);
        mute = 1'b0; word(24'sh400000, -24'sh400000);
        cur_req = "R8";               // pulse between ticks
        cfg = 1'b1; cycle(); cfg = 1'b0;
        rand_words(3072);
        word(24'sh0ABCDE, -24'sh0ABCDE);
        rand_words(5);
        cur_req = "R8";               // pulse on a tick
        tick = 1'b1; cfg = 1'b1; in_l = 24'sh111111; in_r = 24'sh222222;
        cycle();
        tick = 1'b0; cfg = 1'b0; cycle();
        rand_words(3071);
        word(24'sh0FEDCB, -24'sh0FEDCB);
        cur_req = "R10";
        for (int i = 0; i < 6; i++) cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule